// File: doc/BRIEF.md
# Overcurrent Hiccup Retry Timer

This block supervises a number of independent output channels (two by default) for sustained overcurrent. Each channel receives a synchronous overcurrent flag from an external comparator. When dynamic limiting is active and the flag stays high longer than a qualification window, the channel turns its output off for a fixed forced-off window and raises an overload flag. It then runs a soft-start window with the output back on, and returns to normal supervision. If the fault is still there, the cycle repeats for as long as the fault lasts.

All windows are counted in ticks. A shared divider produces a one-cycle tick every `TICK_DIV` clocks. The default is a 1 ms tick from a 100 MHz clock, with windows of 51, 900 and 20 ticks. A static-limit input turns the hiccup behaviour off for every channel. A per-channel enable input takes the channel down at once.

Top module: `ocp_retry_timer`

## Requirements
- R1: While reset is asserted, every `out_en`, `soft_act` and `olf` bit is low.
- R2: The tick is a single-cycle pulse every `TICK_DIV` clocks. The forced-off window lasts exactly `OFF_TICKS*TICK_DIV` clocks, and the soft-start window lasts exactly `SS_TICKS*TICK_DIV` clocks.
- R3: When `ch_en[i]` is low at a clock edge, all three outputs of channel i are low after that edge. This holds even in the cycle where a forced-off window would expire. When `ch_en[i]` is high and no fault is pending, `out_en[i]` is high one cycle later with `olf[i]` low.
- R4: With `static_lim` low, the channel trips on the (`QUAL_TICKS`+1)-th consecutive tick sampled with `oc[i]` high. After that edge, `out_en[i]` is low and `olf[i]` is high.
- R5: A single cycle with `oc[i]` low clears the qualification count. Two fault bursts of `QUAL_TICKS*TICK_DIV` cycles each, separated by one clear cycle, cause no trip.
- R6: For the whole forced-off window, `olf[i]` is high and `out_en[i]` is low.
- R7: When the forced-off window ends, `olf[i]` goes low, and `soft_act[i]` and `out_en[i]` are high for the soft-start window. `oc[i]` is ignored during soft-start.
- R8: After soft-start, qualification restarts from zero. With the fault still present, the next trip comes exactly (`QUAL_TICKS`+1)*`TICK_DIV` clocks after soft-start ends.
- R9: While `static_lim` is high, no enabled channel ever trips. Raising it during a forced-off window returns the channel to a running output with `olf` low on the next cycle.
- R10: Channels are independent: a fault sequence on one channel leaves another channel's outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_en | input | NCH | Per-channel enable |
| static_lim | input | 1 | High selects static limiting; hiccup timing idle |
| oc | input | NCH | Synchronous overcurrent comparison result per channel |
| out_en | output | NCH | Output stage enable per channel |
| soft_act | output | NCH | Soft-start window active per channel |
| olf | output | NCH | Overload flag, high during the forced-off window |

## Verification
Two events can land on the same clock edge: the tick that ends a forced-off window and a drop of the channel enable. The bench finds the first cycle with the flag high. It then counts off the window length and drops the enable so that the drop meets the expiry tick on the same edge. It judges the result by checking that no soft-start or output enable appears afterwards. A second pairing, the clear of a fault against an advancing qualification count, is provoked with a single low cycle between two maximal bursts, and the bench checks that no trip follows.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

  typedef enum logic [1:0] {
    ST_DIS  = 2'd0,
    ST_RUN  = 2'd1,
    ST_OFF  = 2'd2,
    ST_SOFT = 2'd3
  } hic_state_e;

  // Bits needed to hold values 0..n
  function automatic int cnt_w(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Index of the final tick of a window lasting n ticks
  function automatic int last_tick(input int n);
    return (n < 1) ? 0 : n - 1;
  endfunction

endpackage

// File: rtl/ocp_tick_gen.sv
module ocp_tick_gen #(
  parameter int TICK_DIV = 100000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  import ocp_pkg::*;

  localparam int DW = cnt_w(TICK_DIV);

  generate
    if (TICK_DIV <= 1) begin : g_every
      assign tick = rst_n;
    end else begin : g_div
      logic [DW-1:0] div_q;
      logic          wrap;

      assign wrap = (div_q == DW'(TICK_DIV - 1));
      assign tick = wrap;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else if (wrap) div_q <= '0;
        else div_q <= div_q + 1'b1;
      end

      AST_TICK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick) else $error("tick wider than one cycle"); // R2
    end
  endgenerate

endmodule

// File: rtl/ocp_hiccup_ch.sv
module ocp_hiccup_ch #(
  parameter int QUAL_TICKS = 51,
  parameter int OFF_TICKS  = 900,
  parameter int SS_TICKS   = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic ch_en,
  input  logic static_lim,
  input  logic oc,
  output logic out_en,
  output logic soft_act,
  output logic olf
);
  import ocp_pkg::*;

  localparam int TW = cnt_w(max3(QUAL_TICKS, OFF_TICKS, SS_TICKS));

  hic_state_e    st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;

  // Named internal events
  logic qual_done, off_done, ss_done, trip_evt;

  assign qual_done = (st_q == ST_RUN)  && (tmr_q == TW'(QUAL_TICKS));
  assign off_done  = (st_q == ST_OFF)  && (tmr_q == TW'(last_tick(OFF_TICKS)));
  assign ss_done   = (st_q == ST_SOFT) && (tmr_q == TW'(last_tick(SS_TICKS)));
  assign trip_evt  = qual_done && oc && tick;

  always_comb begin
    st_d  = st_q;
    tmr_d = tmr_q;
    if (!ch_en) begin
      st_d  = ST_DIS;
      tmr_d = '0;
    end else if (static_lim) begin
      st_d  = ST_RUN;
      tmr_d = '0;
    end else begin
      unique case (st_q)
        ST_DIS: begin
          st_d  = ST_RUN;
          tmr_d = '0;
        end
        ST_RUN: begin
          if (!oc) tmr_d = '0;
          else if (tick) begin
            if (qual_done) begin
              st_d  = ST_OFF;
              tmr_d = '0;
            end else begin
              tmr_d = tmr_q + 1'b1;
            end
          end
        end
        ST_OFF: begin
          if (tick) begin
            if (off_done) begin
              st_d  = ST_SOFT;
              tmr_d = '0;
            end else begin
              tmr_d = tmr_q + 1'b1;
            end
          end
        end
        ST_SOFT: begin
          if (tick) begin
            if (ss_done) begin
              st_d  = ST_RUN;
              tmr_d = '0;
            end else begin
              tmr_d = tmr_q + 1'b1;
            end
          end
        end
        default: begin
          st_d  = ST_DIS;
          tmr_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_DIS;
      tmr_q <= '0;
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
    end
  end

  assign out_en   = (st_q == ST_RUN) || (st_q == ST_SOFT);
  assign soft_act = (st_q == ST_SOFT);
  assign olf      = (st_q == ST_OFF);

  AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_en |=> (!out_en && !olf && !soft_act)) else $error("disable ignored"); // R3
  AST_TRIP_NEEDS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(olf) |-> ($past(oc) && $past(tick) && !$past(static_lim))) else $error("trip without fault tick"); // R4
  AST_QUAL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN) |-> (tmr_q <= TW'(QUAL_TICKS))) else $error("qualification overrun"); // R5
  AST_OFF_MEANS_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    olf |-> !out_en) else $error("output on during forced-off"); // R6
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (olf && !tick && ch_en && !static_lim) |=> olf) else $error("flag dropped between ticks"); // R6
  AST_SOFT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(olf) && $past(ch_en) && !$past(static_lim)) |-> (soft_act && out_en)) else $error("no soft-start after off"); // R7
  AST_STATIC_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (static_lim && ch_en) |=> (out_en && !olf && !soft_act)) else $error("static mode tripped"); // R9

endmodule

// File: rtl/ocp_retry_timer.sv
module ocp_retry_timer #(
  parameter int NCH        = 2,
  parameter int TICK_DIV   = 100000,
  parameter int QUAL_TICKS = 51,
  parameter int OFF_TICKS  = 900,
  parameter int SS_TICKS   = 20
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] ch_en,
  input  logic           static_lim,
  input  logic [NCH-1:0] oc,
  output logic [NCH-1:0] out_en,
  output logic [NCH-1:0] soft_act,
  output logic [NCH-1:0] olf
);

  logic ms_tick;

  ocp_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (ms_tick)
  );

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      ocp_hiccup_ch #(
        .QUAL_TICKS(QUAL_TICKS),
        .OFF_TICKS (OFF_TICKS),
        .SS_TICKS  (SS_TICKS)
      ) u_ch (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (ms_tick),
        .ch_en     (ch_en[c]),
        .static_lim(static_lim),
        .oc        (oc[c]),
        .out_en    (out_en[c]),
        .soft_act  (soft_act[c]),
        .olf       (olf[c])
      );
    end
  endgenerate

  AST_RESET_DARK: assert property (@(posedge clk)
    !rst_n |-> (out_en == '0 && olf == '0 && soft_act == '0)) else $error("outputs live in reset"); // R1

endmodule

// File: tb/ocp_retry_timer_test.sv
module ocp_retry_timer_test;
  localparam int NCH  = 2;
  localparam int DIV  = 4;
  localparam int QUAL = 6;
  localparam int OFFT = 10;
  localparam int SST  = 5;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] ch_en = '0;
  logic           static_lim = 1'b0;
  logic [NCH-1:0] oc = '0;
  logic [NCH-1:0] out_en, soft_act, olf;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  ocp_retry_timer #(
    .NCH(NCH), .TICK_DIV(DIV), .QUAL_TICKS(QUAL), .OFF_TICKS(OFFT), .SS_TICKS(SST)
  ) uut (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .static_lim(static_lim),
    .oc(oc), .out_en(out_en), .soft_act(soft_act), .olf(olf)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic reset_dut();
    @(negedge clk);
    rst_n = 1'b0; ch_en = '0; oc = '0; static_lim = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0; ch_en = '1; oc = '1;
    repeat (2) @(negedge clk);
    chk({out_en, soft_act, olf} == '0, "R1 outputs in reset", int'({out_en, soft_act, olf}), 0);
    reset_dut();
  endtask

  task automatic t_enable();
    reset_dut();
    ch_en = 2'b11;
    @(negedge clk);
    chk(out_en == 2'b11, "R3 enable brings outputs up", int'(out_en), 3);
    chk(olf == 2'b00 && soft_act == 2'b00, "R3 no flag after enable", int'({olf, soft_act}), 0);
  endtask

  task automatic t_hiccup();
    int n, k, m, r, bad;
    reset_dut();
    ch_en = 2'b11;
    @(negedge clk);
    oc[0] = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (out_en[0] && n < 1000);
    chk(n > QUAL*DIV && n <= (QUAL+1)*DIV, "R4 trip delay", n, (QUAL+1)*DIV);
    chk(olf[0] == 1'b1, "R4 flag raised at trip", int'(olf[0]), 1);
    chk(out_en[1] == 1'b1 && olf[1] == 1'b0, "R10 other channel unaffected", int'({out_en[1], olf[1]}), 2);
    k = 0; bad = 0;
    while (olf[0] && k < 1000) begin
      if (out_en[0]) bad++;
      k++;
      @(negedge clk);
    end
    chk(k == OFFT*DIV, "R6 R2 forced-off length", k, OFFT*DIV);
    chk(bad == 0, "R6 output dark while flagged", bad, 0);
    m = 0; bad = 0;
    while (soft_act[0] && m < 1000) begin
      if (!out_en[0] || olf[0]) bad++;
      m++;
      @(negedge clk);
    end
    chk(m == SST*DIV, "R7 R2 soft-start length with fault held", m, SST*DIV);
    chk(bad == 0, "R7 output on and flag low in soft-start", bad, 0);
    r = 0;
    while (out_en[0] && !soft_act[0] && r < 1000) begin
      r++;
      @(negedge clk);
    end
    chk(r == (QUAL+1)*DIV, "R8 requalification time", r, (QUAL+1)*DIV);
    chk(olf[0] == 1'b1, "R8 repeat trip", int'(olf[0]), 1);
    chk(out_en[1] == 1'b1, "R10 other channel still on", int'(out_en[1]), 1);
    oc = '0;
  endtask

  task automatic t_clear();
    int bad;
    reset_dut();
    ch_en = 2'b11;
    @(negedge clk);
    bad = 0;
    oc[0] = 1'b1;
    repeat (QUAL*DIV) begin @(negedge clk); if (!out_en[0] || olf[0]) bad++; end
    oc[0] = 1'b0;
    @(negedge clk);
    oc[0] = 1'b1;
    repeat (QUAL*DIV) begin @(negedge clk); if (!out_en[0] || olf[0]) bad++; end
    oc[0] = 1'b0;
    repeat (2*DIV) begin @(negedge clk); if (!out_en[0] || olf[0]) bad++; end
    chk(bad == 0, "R5 cleared fault never trips", bad, 0);
  endtask

  task automatic t_static();
    int bad, n;
    reset_dut();
    static_lim = 1'b1;
    ch_en = 2'b11;
    oc = 2'b11;
    bad = 0;
    @(negedge clk);
    repeat ((QUAL+4)*DIV) begin @(negedge clk); if (out_en != 2'b11 || olf != 2'b00) bad++; end
    chk(bad == 0, "R9 static mode never trips", bad, 0);
    static_lim = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (!olf[0] && n < 1000);
    chk(olf[0] == 1'b1, "R9 hiccup resumes when static drops", int'(olf[0]), 1);
    repeat (3) @(negedge clk);
    static_lim = 1'b1;
    @(negedge clk);
    chk(out_en[0] == 1'b1 && olf[0] == 1'b0, "R9 static mid-off restores output", int'({out_en[0], olf[0]}), 2);
    oc = '0;
    static_lim = 1'b0;
  endtask

  task automatic t_race();
    int n, bad;
    reset_dut();
    ch_en = 2'b11;
    @(negedge clk);
    oc[0] = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!olf[0] && n < 1000);
    repeat (OFFT*DIV - 1) @(negedge clk);
    ch_en[0] = 1'b0;
    @(negedge clk);
    chk({out_en[0], soft_act[0], olf[0]} == 3'b000, "R3 disable wins over expiry",
        int'({out_en[0], soft_act[0], olf[0]}), 0);
    bad = 0;
    repeat (3*DIV) begin @(negedge clk); if (out_en[0] || soft_act[0] || olf[0]) bad++; end
    chk(bad == 0, "R3 stays down while disabled", bad, 0);
    oc[0] = 1'b0;
    ch_en[0] = 1'b1;
    @(negedge clk);
    chk(out_en[0] == 1'b1 && olf[0] == 1'b0, "R3 re-enable clean", int'({out_en[0], olf[0]}), 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_enable();
    t_hiccup();
    t_clear();
    t_static();
    t_race();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule